// File: doc/BRIEF.md
# Banked Microcontroller Memory Decoder

This block sits beside an 8-bit microcontroller with a 16-bit address bus and turns each bus address into active-low chip selects for an external flash, an external EEPROM, external SRAM, the controller's internal RAM and EEPROM, a boot ROM and three peripheral windows. A larger flash than the 64 KB address space is reached by driving four extra high address lines. The upper 32 KB of the map is a fixed common flash region. The 16 KB window at 0x4000 shows one flash bank chosen by software, or the external EEPROM instead of flash.

Software programs the map through sixteen byte-wide configuration registers at 0x1400, reached with the CPU's I/O select, a write enable and the address bus. A strap input selects a bootstrap map. In that map the internal EEPROM covers the top of memory, the internal RAM sits at address zero and a boot ROM overlays part of the common flash. The CPU's own SRAM, program and I/O selects are inputs. The SRAM select is passed through, and the program and I/O selects qualify the flash and EEPROM decode. All selects and the extended address are registered.

Top module: `mmd_top`

## Requirements
- R1: After synchronous reset, every chip select output is high, `ext_addr` is 0 and each of the sixteen configuration registers reads back 0.
- R2: When `io_sel_n` is low and `addr` is in 0x1400–0x140F, the register with index `addr[3:0]` is accessed. If `wr_en` is 1, it takes `wdata` at the clock edge. If `wr_en` is 0, its value appears on `rdata` after that edge, and `rdata` holds otherwise. Index 0 holds the flash bank in bits 3:0. Bit 0 of index 1 enables the EEPROM swap. Indices 2+2n and 3+2n hold the first and last page of peripheral window n. Bit n of index 8 enables window n.
- R3: A write is ignored when `addr` is in 0x1410–0x14FF or `io_sel_n` is high.
- R4: In normal mode, with `prog_sel_n` low, any address in 0x8000–0xFFFF (which includes the reset vector at 0xFFFE/0xFFFF) asserts `flash_cs_n` and drives `ext_addr` = {000, addr[14]}.
- R5: In normal mode, with the swap disabled and `prog_sel_n` low, 0x4000–0x7FFF asserts `flash_cs_n`, and `ext_addr` equals the bank field of register 0.
- R6: With the swap enabled, 0x4000–0x7FFF asserts `eeprom_cs_n` only when `io_sel_n` is low, never asserts `flash_cs_n`, and drives `ext_addr` = 0.
- R7: Peripheral select n is low exactly when window n is enabled and first page ≤ addr[15:8] ≤ last page, with both bounds inclusive. This is independent of the memory decode.
- R8: When `boot_mode` is 1, 0x0000–0x03FF asserts `int_ram_cs_n`, 0xFE00–0xFFFF asserts `int_ee_cs_n` and 0xB600–0xBFFF asserts `boot_rom_cs_n`. Each of these overrides flash and SRAM.
- R9: `sram_cs_n` follows a low `sram_sel_n`, except when another memory select is asserted or when `io_sel_n` is low with the address in 0x1400–0x14FF.
- R10: In normal mode, 0x0400–0x07FF asserts `int_ram_cs_n`, 0x1600–0x17FF asserts `int_ee_cs_n`, and the boot ROM is never selected.
- R11: Every output changes only at a rising clock edge and reflects the inputs sampled at that edge.
- R12: At most one of the six memory selects (flash, EEPROM, SRAM, internal RAM, internal EEPROM, boot ROM) is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | CPU address bus |
| wr_en | input | 1 | 1 = write, 0 = read for register accesses |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| boot_mode | input | 1 | Selects the bootstrap map |
| sram_sel_n | input | 1 | CPU SRAM select, active low |
| prog_sel_n | input | 1 | CPU program-space select, active low |
| io_sel_n | input | 1 | CPU I/O select, active low |
| flash_cs_n | output | 1 | External flash select |
| eeprom_cs_n | output | 1 | External EEPROM select |
| sram_cs_n | output | 1 | External SRAM select |
| int_ram_cs_n | output | 1 | Internal RAM select |
| int_ee_cs_n | output | 1 | Internal EEPROM select |
| boot_rom_cs_n | output | 1 | Boot ROM select |
| periph_cs_n | output | 3 | Peripheral window selects |
| ext_addr | output | 4 | Extended flash address bits 17:14 |

## Verification
Every select, `ext_addr` and `rdata` is due on the first rising edge after the inputs are driven, so each result has a latency of exactly one cycle. A register write changes the decode only from the edge after the one that stores it. The driver changes the inputs at a falling edge and computes the expected result from a shadow register model that still holds the values from before the write. It pushes that result into the queue after the next rising edge. The monitor pops and compares the result at the falling edge that follows, and a separate check confirms that nothing moves before that edge.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int ADDR_W = 16;

  // configuration register indices
  localparam int RI_BANK     = 0;
  localparam int RI_CTRL     = 1;
  localparam int RI_WIN_BASE = 2;

  // address map
  localparam logic [ADDR_W-1:0] CFG_BASE      = 16'h1400;
  localparam logic [ADDR_W-1:0] CFG_LAST      = 16'h14FF;
  localparam logic [ADDR_W-1:0] IRAM_N_LO     = 16'h0400;
  localparam logic [ADDR_W-1:0] IRAM_N_HI     = 16'h07FF;
  localparam logic [ADDR_W-1:0] IEE_N_LO      = 16'h1600;
  localparam logic [ADDR_W-1:0] IEE_N_HI      = 16'h17FF;
  localparam logic [ADDR_W-1:0] IRAM_B_HI     = 16'h03FF;
  localparam logic [ADDR_W-1:0] IEE_B_LO      = 16'hFE00;
  localparam logic [ADDR_W-1:0] BROM_LO       = 16'hB600;
  localparam logic [ADDR_W-1:0] BROM_HI       = 16'hBFFF;

  typedef struct packed {
    logic flash;
    logic eeprom;
    logic sram;
    logic iram;
    logic iee;
    logic brom;
  } mem_sel_t;
endpackage

// File: rtl/mmd_regfile.sv
module mmd_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] regs_o [NUM_REGS]
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
      rdata_q <= '0;
    end else if (acc_en) begin
      if (wr_en) regs_q[idx] <= wdata;
      else       rdata_q     <= regs_q[idx];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs_o[i] = regs_q[i];
  end
  assign rdata = rdata_q;

  // R2: a decoded write lands in the addressed register
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_en && wr_en) |=> (regs_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/mmd_periph_win.sv
module mmd_periph_win #(
  parameter int PAGE_W = 8
) (
  input  logic              en,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] last_pg,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  assign hit = en && (page >= first_pg) && (page <= last_pg);
endmodule

// File: rtl/mmd_mem_decode.sv
module mmd_mem_decode
  import mmd_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot,
  input  logic              sram_sel,
  input  logic              prog_sel,
  input  logic              io_sel,
  input  logic              swap,
  input  logic [BANK_W-1:0] bank,
  output mem_sel_t          sel,
  output logic [BANK_W-1:0] ext
);
  logic in_cfg, common, banked, internal;

  always_comb begin
    sel    = '0;
    ext    = '0;
    in_cfg = io_sel && (addr >= CFG_BASE) && (addr <= CFG_LAST);
    common = addr[ADDR_W-1];
    banked = (addr[ADDR_W-1 -: 2] == 2'b01);

    if (boot) begin
      sel.iram = (addr <= IRAM_B_HI);
      sel.iee  = (addr >= IEE_B_LO);
      sel.brom = (addr >= BROM_LO) && (addr <= BROM_HI);
    end else begin
      sel.iram = (addr >= IRAM_N_LO) && (addr <= IRAM_N_HI);
      sel.iee  = (addr >= IEE_N_LO) && (addr <= IEE_N_HI);
    end
    internal = sel.iram || sel.iee || sel.brom;

    sel.flash  = !internal && prog_sel && (common || (banked && !swap));
    sel.eeprom = !internal && io_sel && banked && swap;
    sel.sram   = sram_sel && !internal && !sel.flash && !sel.eeprom && !in_cfg;

    if (sel.flash) begin
      if (banked) ext = bank;
      else        ext = {{(BANK_W-1){1'b0}}, addr[ADDR_W-2]};
    end
  end
endmodule

// File: rtl/mmd_top.sv
module mmd_top
  import mmd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 4,
  parameter int NUM_PERIPH = 3,
  parameter int NUM_REGS   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic                  boot_mode,
  input  logic                  sram_sel_n,
  input  logic                  prog_sel_n,
  input  logic                  io_sel_n,
  output logic                  flash_cs_n,
  output logic                  eeprom_cs_n,
  output logic                  sram_cs_n,
  output logic                  int_ram_cs_n,
  output logic                  int_ee_cs_n,
  output logic                  boot_rom_cs_n,
  output logic [NUM_PERIPH-1:0] periph_cs_n,
  output logic [BANK_W-1:0]     ext_addr
);
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int PAGE_W    = ADDR_W - 8;
  localparam int RI_WIN_EN = RI_WIN_BASE + 2 * NUM_PERIPH;

  logic                  acc_en;
  logic [DATA_W-1:0]     cfg_regs [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] cfg_flat;
  logic [NUM_PERIPH-1:0] win_hit;
  mem_sel_t              sel;
  logic [BANK_W-1:0]     ext_d;

  assign acc_en = !io_sel_n && (addr[ADDR_W-1:IDX_W] == CFG_BASE[ADDR_W-1:IDX_W]);

  mmd_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .acc_en (acc_en),
    .wr_en  (wr_en),
    .idx    (addr[IDX_W-1:0]),
    .wdata  (wdata),
    .rdata  (rdata),
    .regs_o (cfg_regs)
  );

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) cfg_flat[i*DATA_W +: DATA_W] = cfg_regs[i];
  end

  for (genvar w = 0; w < NUM_PERIPH; w++) begin : g_win
    mmd_periph_win #(.PAGE_W(PAGE_W)) u_win (
      .en       (cfg_regs[RI_WIN_EN][w]),
      .first_pg (cfg_regs[RI_WIN_BASE + 2*w][PAGE_W-1:0]),
      .last_pg  (cfg_regs[RI_WIN_BASE + 2*w + 1][PAGE_W-1:0]),
      .page     (addr[ADDR_W-1 -: PAGE_W]),
      .hit      (win_hit[w])
    );

    // R7: a disabled window never selects its peripheral
    p_win_off_r7: assert property (@(posedge clk) disable iff (rst)
      !cfg_regs[RI_WIN_EN][w] |=> periph_cs_n[w]);
  end

  mmd_mem_decode #(.BANK_W(BANK_W)) u_dec (
    .addr     (addr),
    .boot     (boot_mode),
    .sram_sel (!sram_sel_n),
    .prog_sel (!prog_sel_n),
    .io_sel   (!io_sel_n),
    .swap     (cfg_regs[RI_CTRL][0]),
    .bank     (cfg_regs[RI_BANK][BANK_W-1:0]),
    .sel      (sel),
    .ext      (ext_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flash_cs_n    <= 1'b1;
      eeprom_cs_n   <= 1'b1;
      sram_cs_n     <= 1'b1;
      int_ram_cs_n  <= 1'b1;
      int_ee_cs_n   <= 1'b1;
      boot_rom_cs_n <= 1'b1;
      periph_cs_n   <= '1;
      ext_addr      <= '0;
    end else begin
      flash_cs_n    <= !sel.flash;
      eeprom_cs_n   <= !sel.eeprom;
      sram_cs_n     <= !sel.sram;
      int_ram_cs_n  <= !sel.iram;
      int_ee_cs_n   <= !sel.iee;
      boot_rom_cs_n <= !sel.brom;
      periph_cs_n   <= ~win_hit;
      ext_addr      <= ext_d;
    end
  end

  // R1: selects are idle right after a reset edge
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (flash_cs_n && eeprom_cs_n && sram_cs_n && int_ram_cs_n
                    && int_ee_cs_n && boot_rom_cs_n && (periph_cs_n == '1)));

  // R3: accesses outside the decoded registers leave every register unchanged
  p_stray_write_r3: assert property (@(posedge clk) disable iff (rst)
    (io_sel_n || (addr[ADDR_W-1:IDX_W] != CFG_BASE[ADDR_W-1:IDX_W])) |=> $stable(cfg_flat));

  // R4: reset vector fetch hits common flash in normal mode
  p_vector_flash_r4: assert property (@(posedge clk) disable iff (rst)
    (!boot_mode && !prog_sel_n && (addr >= 16'hFFFE)) |=> (!flash_cs_n && (ext_addr == 1)));

  // R8: in the bootstrap map the vector comes from internal EEPROM
  p_boot_vector_r8: assert property (@(posedge clk) disable iff (rst)
    (boot_mode && (addr >= 16'hFFFE)) |=> (!int_ee_cs_n && flash_cs_n));

  // R9: SRAM select passes through over a region nothing else claims
  p_sram_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (!boot_mode && !sram_sel_n && (addr >= 16'h2000) && (addr <= 16'h3FFF)) |=> !sram_cs_n);

  // R12: memory selects are mutually exclusive
  p_one_mem_r12: assert property (@(posedge clk) disable iff (rst)
    $countones({~flash_cs_n, ~eeprom_cs_n, ~sram_cs_n, ~int_ram_cs_n,
                ~int_ee_cs_n, ~boot_rom_cs_n}) <= 1);
endmodule

// File: tb/mmd_top_tb_top.sv
module mmd_top_tb_top;
  typedef struct packed {
    logic [3:0] ext;
    logic [2:0] per;
    logic       brom, iee, iram, sram, eep, flash;
    logic [7:0] rd;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h2000;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        boot_mode = 1'b0;
  logic        sram_sel_n = 1'b1, prog_sel_n = 1'b1, io_sel_n = 1'b1;
  logic [7:0]  rdata;
  logic        flash_cs_n, eeprom_cs_n, sram_cs_n, int_ram_cs_n, int_ee_cs_n, boot_rom_cs_n;
  logic [2:0]  periph_cs_n;
  logic [3:0]  ext_addr;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [7:0] m_regs [16];
  logic [7:0] m_rd = '0;

  always #4 clk = ~clk;

  mmd_top dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .boot_mode(boot_mode), .sram_sel_n(sram_sel_n), .prog_sel_n(prog_sel_n),
    .io_sel_n(io_sel_n), .flash_cs_n(flash_cs_n), .eeprom_cs_n(eeprom_cs_n),
    .sram_cs_n(sram_cs_n), .int_ram_cs_n(int_ram_cs_n), .int_ee_cs_n(int_ee_cs_n),
    .boot_rom_cs_n(boot_rom_cs_n), .periph_cs_n(periph_cs_n), .ext_addr(ext_addr)
  );

  function automatic exp_t model(logic [15:0] a, logic wr, logic io_n, logic prog_n,
                                 logic sram_n, logic bt);
    exp_t e;
    logic iram, iee, brom, intl, fl, ee, sr, bnk;
    if (bt) begin
      iram = a < 16'h0400; iee = a >= 16'hFE00; brom = a >= 16'hB600 && a < 16'hC000;
    end else begin
      iram = a >= 16'h0400 && a < 16'h0800; iee = a >= 16'h1600 && a < 16'h1800; brom = 0;
    end
    intl = iram | iee | brom;
    bnk  = a >= 16'h4000 && a < 16'h8000;
    fl   = !intl && !prog_n && (a >= 16'h8000 || (bnk && !m_regs[1][0]));
    ee   = !intl && !io_n && bnk && m_regs[1][0];
    sr   = !sram_n && !intl && !fl && !ee && !(!io_n && a[15:8] == 8'h14);
    e.flash = !fl; e.eep = !ee; e.sram = !sr; e.iram = !iram; e.iee = !iee; e.brom = !brom;
    e.ext = !fl ? 4'd0 : (bnk ? m_regs[0][3:0] : {3'b000, a[14]});
    for (int i = 0; i < 3; i++)
      e.per[i] = !(m_regs[8][i] && a[15:8] >= m_regs[2+2*i] && a[15:8] <= m_regs[3+2*i]);
    e.rd = (!io_n && !wr && a[15:4] == 12'h140) ? m_regs[a[3:0]] : m_rd;
    return e;
  endfunction

  task automatic cyc(input logic [15:0] a, input logic wr, input logic [7:0] wd,
                     input logic io_n, input logic prog_n, input logic sram_n, input string tag);
    exp_t e;
    @(negedge clk);
    addr = a; wr_en = wr; wdata = wd; io_sel_n = io_n; prog_sel_n = prog_n; sram_sel_n = sram_n;
    e = model(a, wr, io_n, prog_n, sram_n, boot_mode);
    m_rd = e.rd;
    if (!io_n && wr && a[15:4] == 12'h140) m_regs[a[3:0]] = wd;
    @(posedge clk); #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [7:0] v, input string tag);
    cyc({12'h140, idx}, 1'b1, v, 1'b0, 1'b1, 1'b1, tag);
  endtask

  task automatic rd_reg(input logic [3:0] idx, input string tag);
    cyc({12'h140, idx}, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, tag);
  endtask

  task automatic fetch(input logic [15:0] a, input string tag);
    cyc(a, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, tag);
  endtask

  task automatic direct(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: compare each result one cycle after its stimulus
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      exp_t e, act;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = {ext_addr, periph_cs_n, boot_rom_cs_n, int_ee_cs_n, int_ram_cs_n,
             sram_cs_n, eeprom_cs_n, flash_cs_n, rdata};
      n_tests++;
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", t, act, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_regs[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    direct({flash_cs_n, eeprom_cs_n, sram_cs_n, int_ram_cs_n, int_ee_cs_n, boot_rom_cs_n,
            periph_cs_n} == 9'h1FF && ext_addr == 0 && rdata == 0, "R1 reset outputs",
           {ext_addr, periph_cs_n, rdata}, 32'h0000_0700);
    for (int i = 0; i < 16; i += 5) rd_reg(4'(i), "R1 register cleared");

    // R4 common flash and reset vector
    fetch(16'h8000, "R4 common low");
    fetch(16'hC123, "R4 common high half");
    fetch(16'hFFFE, "R4 reset vector");
    fetch(16'hFFFF, "R4 reset vector high");

    // R5 banked flash, R2 readback of full byte
    wr_reg(4'd0, 8'hA5, "R2 write bank");
    fetch(16'h4000, "R5 bank window low");
    fetch(16'h7FFF, "R5 bank window high");
    rd_reg(4'd0, "R2 readback bank");
    wr_reg(4'd15, 8'h3C, "R2 write spare");
    rd_reg(4'd15, "R2 readback spare");

    // R3 ignored writes
    cyc(16'h1410, 1'b1, 8'h77, 1'b0, 1'b1, 1'b1, "R3 write past decoded regs");
    cyc(16'h1400, 1'b1, 8'h11, 1'b1, 1'b1, 1'b1, "R3 write without io select");
    rd_reg(4'd0, "R3 bank unchanged");
    fetch(16'h5000, "R3 bank still 5");

    // R6 EEPROM swap
    wr_reg(4'd1, 8'h01, "R6 enable swap");
    cyc(16'h5000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R6 swapped window with io select");
    cyc(16'h6000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R6 swapped window without io select");
    fetch(16'h9000, "R6 common unaffected");
    cyc(16'h4000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R12 eeprom with sram request");
    wr_reg(4'd1, 8'h00, "R6 disable swap");

    // R7 peripheral windows
    wr_reg(4'd2, 8'h20, "R7 win0 first");
    wr_reg(4'd3, 8'h2F, "R7 win0 last");
    fetch(16'h2400, "R7 in range but disabled");
    wr_reg(4'd4, 8'h90, "R7 win1 first");
    wr_reg(4'd5, 8'h90, "R7 win1 last");
    wr_reg(4'd6, 8'hF0, "R7 win2 first");
    wr_reg(4'd7, 8'h10, "R7 win2 last");
    wr_reg(4'd8, 8'h07, "R7 enable windows");
    fetch(16'h1FFF, "R7 below win0");
    fetch(16'h2000, "R7 win0 first page");
    fetch(16'h2FFF, "R7 win0 last page");
    fetch(16'h3000, "R7 above win0");
    fetch(16'h90AB, "R7 win1 single page");
    fetch(16'h9100, "R7 past win1");
    fetch(16'hF800, "R7 win2 inverted never");

    // R9 SRAM passthrough
    cyc(16'h2000, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R9 sram pass");
    cyc(16'h8000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R9 sram suppressed by flash");
    cyc(16'h1405, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R9 sram suppressed in register window");
    cyc(16'h14F0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R9 sram when io select high");

    // R10 normal internal memories
    cyc(16'h03FF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R10 below internal ram");
    cyc(16'h0400, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R10 internal ram low");
    cyc(16'h07FF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R10 internal ram high");
    cyc(16'h1600, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R10 internal eeprom");
    cyc(16'hB700, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R10 no boot rom");

    // R8 bootstrap map
    boot_mode = 1'b1;
    cyc(16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8 boot internal ram low");
    cyc(16'h03FF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8 boot internal ram high");
    cyc(16'h0400, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8 boot past internal ram");
    fetch(16'hB5FF, "R8 below boot rom");
    fetch(16'hB600, "R8 boot rom low");
    fetch(16'hBFFF, "R8 boot rom high");
    fetch(16'hFDFF, "R8 below internal eeprom");
    fetch(16'hFFFE, "R8 boot vector");
    fetch(16'h1600, "R8 normal eeprom slot freed");
    boot_mode = 1'b0;
    fetch(16'h2000, "R11 idle");

    repeat (2) @(negedge clk);
    // R11: no change before the edge, change right after it
    addr = 16'h8000; prog_sel_n = 1'b0; sram_sel_n = 1'b1; io_sel_n = 1'b1;
    #1;
    direct(flash_cs_n == 1'b1, "R11 before edge", 32'(flash_cs_n), 32'h1);
    @(posedge clk); #1;
    direct(flash_cs_n == 1'b0, "R11 after edge", 32'(flash_cs_n), 32'h0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule